// File: doc/BRIEF.md
# Compact Hidden-Bit Floating-Point Adder

This block sums two positive, normalized floating-point numbers held in a compact format. Each operand is a stored fraction of `FW` bits (8 by default) with an implied leading one, plus an unsigned exponent code of `EW` bits (3 by default) in excess code. The value is 1.fraction times two raised to the exponent code minus the bias. The bias never enters the arithmetic, because both operands and the result share it.

An operation begins when `start` is high while `ready` is high. On that edge the block registers the aligned operands: the one with the larger exponent code becomes the reference, and the other significand, hidden one included, is shifted right by the exponent difference. On the next edge it adds the two significands and post-normalizes the sum. It then registers the result and pulses `done` for one cycle. The result stays on the outputs until the next operation completes.

All bits shifted out are dropped, so the result is truncated. When post-normalization would push the exponent code past its largest value, the block raises `overflow` and saturates the result.

Top module: `fpa_add_top`

## Requirements
- R1: While `rst` is high and after it is released, `ready` is 1 and `done`, `overflow`, `sum_frac` and `sum_exp` are 0.
- R2: `start` is sampled only on an edge where `ready` is 1. On the accepting edge `ready` goes to 0. On the edge after that, `done` goes to 1 for exactly one cycle and `ready` returns to 1. A `start` seen while `ready` is 0 has no effect on the result, and no extra `done` follows it.
- R3: The operand with the larger exponent code is the reference, and operand A is the reference when the codes are equal. The other significand (1 followed by its fraction) is shifted right by the code difference and truncated. Without a carry, `sum_frac` is the low `FW` bits of the significand sum and `sum_exp` is the reference exponent code.
- R4: When the exponent difference is at least `FW`+1, the smaller operand contributes zero. The result then equals the reference operand.
- R5: When the significand sum reaches 2.0 (bit `FW`+1 of the sum is set), the sum is shifted right one place and truncated. `sum_frac` takes sum bits `FW` down to 1, and `sum_exp` is the reference code plus one. For example, fractions 11000000 (exponent 011) and 10101100 (exponent 100) give fraction 01000110, exponent 101.
- R6: When the case of R5 occurs with the reference code at its maximum (all ones), `overflow` is 1 and `sum_frac` and `sum_exp` are all ones. In every other case `overflow` is 0.
- R7: `sum_frac`, `sum_exp` and `overflow` change only on the edge that raises `done`. They hold their values through any later input activity until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an addition |
| a_frac | input | FW | Stored fraction of operand A |
| a_exp | input | EW | Exponent code of operand A |
| b_frac | input | FW | Stored fraction of operand B |
| b_exp | input | EW | Exponent code of operand B |
| ready | output | 1 | Block is idle and will accept `start` |
| done | output | 1 | One-cycle pulse when a new result is registered |
| sum_frac | output | FW | Stored fraction of the result |
| sum_exp | output | EW | Exponent code of the result |
| overflow | output | 1 | Result saturated because the exponent code overflowed |

## Verification
The completion of one addition and the acceptance of the next can fall on the same cycle. This is because `ready` returns high together with `done`. The sweep keeps operations back to back, with each new `start` presented in the cycle where the previous `done` is visible. Every result is compared against an arithmetic model of truncated alignment, carry normalization and saturation, which shows that overlapping a completion with an acceptance never corrupts either result. A second overlap, a `start` raised during the busy cycle, is also provoked. There the check is that the completing result belongs to the first operands and that no second `done` appears.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_ADD  = 1'b1
  } fpa_state_t;

endpackage

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int FW = 8,
  parameter int EW = 3,
  localparam int SW = FW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] a_frac,
  input  logic [EW-1:0] a_exp,
  input  logic [FW-1:0] b_frac,
  input  logic [EW-1:0] b_exp,
  output logic [SW-1:0] ref_sig,
  output logic [SW-1:0] sm_aligned,
  output logic [EW-1:0] ref_exp
);

  logic          b_larger;
  logic [SW-1:0] sm_sig;
  logic [EW-1:0] sm_exp;
  logic [EW-1:0] diff;
  logic          too_far;

  // Operand A is the reference on a tie.
  assign b_larger = (b_exp > a_exp);
  assign ref_sig  = b_larger ? {1'b1, b_frac} : {1'b1, a_frac};
  assign sm_sig   = b_larger ? {1'b1, a_frac} : {1'b1, b_frac};
  assign ref_exp  = b_larger ? b_exp : a_exp;
  assign sm_exp   = b_larger ? a_exp : b_exp;
  assign diff     = ref_exp - sm_exp;
  assign too_far  = (32'(diff) >= SW);

  // Logarithmic right shifter, one stage per difference bit.
  logic [SW-1:0] stage [0:EW];
  assign stage[0] = sm_sig;

  for (genvar k = 0; k < EW; k++) begin : g_shift
    assign stage[k+1] = diff[k] ? (stage[k] >> (1 << k)) : stage[k];
  end

  assign sm_aligned = too_far ? '0 : stage[EW];

  // R3
  ref_not_smaller_chk: assert property (@(posedge clk) disable iff (rst)
    ref_exp >= sm_exp);

  // R3
  shift_never_grows_chk: assert property (@(posedge clk) disable iff (rst)
    sm_aligned <= sm_sig);

  // R3
  hidden_moves_chk: assert property (@(posedge clk) disable iff (rst)
    (diff != '0) |-> (sm_aligned[SW-1] == 1'b0));

endmodule

// File: rtl/fpa_sum_norm.sv
module fpa_sum_norm #(
  parameter int FW = 8,
  parameter int EW = 3,
  localparam int SW = FW + 1,
  localparam logic [EW-1:0] EMAX = {EW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] ref_sig,
  input  logic [SW-1:0] sm_aligned,
  input  logic [EW-1:0] ref_exp,
  output logic [FW-1:0] frac_out,
  output logic [EW-1:0] exp_out,
  output logic          ovf_out
);

  logic [SW:0] raw_sum;
  logic        carry;

  assign raw_sum = {1'b0, ref_sig} + {1'b0, sm_aligned};
  assign carry   = raw_sum[SW];

  always_comb begin
    frac_out = raw_sum[FW-1:0];
    exp_out  = ref_exp;
    ovf_out  = 1'b0;
    if (carry) begin
      if (ref_exp == EMAX) begin
        frac_out = {FW{1'b1}};
        exp_out  = EMAX;
        ovf_out  = 1'b1;
      end else begin
        frac_out = raw_sum[FW:1];
        exp_out  = ref_exp + 1'b1;
      end
    end
  end

  // R6
  ovf_needs_carry_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_out |-> (carry && ref_exp == EMAX));

  // R5
  exp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (exp_out == ref_exp) || (32'(exp_out) == 32'(ref_exp) + 1));

  // R5
  no_carry_keeps_exp_chk: assert property (@(posedge clk) disable iff (rst)
    !carry |-> (exp_out == ref_exp));

endmodule

// File: rtl/fpa_ctrl.sv
module fpa_ctrl
  import fpa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready,
  output logic ld_align,
  output logic ld_result,
  output logic done
);

  fpa_state_t state;

  assign ready     = (state == ST_IDLE);
  assign ld_align  = ready && start;
  assign ld_result = (state == ST_ADD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= ld_result;
      case (state)
        ST_IDLE: if (start) state <= ST_ADD;
        ST_ADD:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> !ready);

  // R2
  done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);

  // R2
  busy_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> done);

endmodule

// File: rtl/fpa_add_top.sv
module fpa_add_top #(
  parameter int FW = 8,
  parameter int EW = 3,
  localparam int SW = FW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [FW-1:0] a_frac,
  input  logic [EW-1:0] a_exp,
  input  logic [FW-1:0] b_frac,
  input  logic [EW-1:0] b_exp,
  output logic          ready,
  output logic          done,
  output logic [FW-1:0] sum_frac,
  output logic [EW-1:0] sum_exp,
  output logic          overflow
);

  logic          ld_align;
  logic          ld_result;
  logic [SW-1:0] al_ref_sig;
  logic [SW-1:0] al_sm;
  logic [EW-1:0] al_ref_exp;
  logic [SW-1:0] q_ref_sig;
  logic [SW-1:0] q_sm;
  logic [EW-1:0] q_ref_exp;
  logic [FW-1:0] n_frac;
  logic [EW-1:0] n_exp;
  logic          n_ovf;

  fpa_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ready     (ready),
    .ld_align  (ld_align),
    .ld_result (ld_result),
    .done      (done)
  );

  fpa_align #(.FW(FW), .EW(EW)) u_align (
    .clk        (clk),
    .rst        (rst),
    .a_frac     (a_frac),
    .a_exp      (a_exp),
    .b_frac     (b_frac),
    .b_exp      (b_exp),
    .ref_sig    (al_ref_sig),
    .sm_aligned (al_sm),
    .ref_exp    (al_ref_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ref_sig <= '0;
      q_sm      <= '0;
      q_ref_exp <= '0;
    end else if (ld_align) begin
      q_ref_sig <= al_ref_sig;
      q_sm      <= al_sm;
      q_ref_exp <= al_ref_exp;
    end
  end

  fpa_sum_norm #(.FW(FW), .EW(EW)) u_norm (
    .clk        (clk),
    .rst        (rst),
    .ref_sig    (q_ref_sig),
    .sm_aligned (q_sm),
    .ref_exp    (q_ref_exp),
    .frac_out   (n_frac),
    .exp_out    (n_exp),
    .ovf_out    (n_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_frac <= '0;
      sum_exp  <= '0;
      overflow <= 1'b0;
    end else if (ld_result) begin
      sum_frac <= n_frac;
      sum_exp  <= n_exp;
      overflow <= n_ovf;
    end
  end

  // R6
  saturate_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (sum_frac == {FW{1'b1}} && sum_exp == {EW{1'b1}}));

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(sum_frac) && $stable(sum_exp) && $stable(overflow)));

endmodule

// File: tb/tb_fpa_add_top.sv
module tb_fpa_add_top;

  localparam int FW  = 8;
  localparam int EW  = 3;
  localparam int EWW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic           start = 1'b0;
  logic [FW-1:0]  a_frac = '0, b_frac = '0;
  logic [EW-1:0]  a_exp = '0, b_exp = '0;
  logic           ready, done, overflow;
  logic [FW-1:0]  sum_frac;
  logic [EW-1:0]  sum_exp;

  logic           w_start = 1'b0;
  logic [FW-1:0]  w_a_frac = '0, w_b_frac = '0;
  logic [EWW-1:0] w_a_exp = '0, w_b_exp = '0;
  logic           w_ready, w_done, w_overflow;
  logic [FW-1:0]  w_sum_frac;
  logic [EWW-1:0] w_sum_exp;

  fpa_add_top #(.FW(FW), .EW(EW)) dut (
    .clk(clk), .rst(rst), .start(start),
    .a_frac(a_frac), .a_exp(a_exp), .b_frac(b_frac), .b_exp(b_exp),
    .ready(ready), .done(done), .sum_frac(sum_frac), .sum_exp(sum_exp),
    .overflow(overflow)
  );

  fpa_add_top #(.FW(FW), .EW(EWW)) dut_wide (
    .clk(clk), .rst(rst), .start(w_start),
    .a_frac(w_a_frac), .a_exp(w_a_exp), .b_frac(w_b_frac), .b_exp(w_b_exp),
    .ready(w_ready), .done(w_done), .sum_frac(w_sum_frac), .sum_exp(w_sum_exp),
    .overflow(w_overflow)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic void check(input string tag, input string what,
                                input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endfunction

  function automatic void model(input int fw, input int ew,
                                input int fa, input int ea,
                                input int fb, input int eb,
                                output int rf, output int re, output int ro,
                                output string tag);
    int sr, ss, er, es, d, sm, s, emax, mask;
    emax = (1 << ew) - 1;
    mask = (1 << fw) - 1;
    if (eb > ea) begin
      sr = (1 << fw) | fb; er = eb; ss = (1 << fw) | fa; es = ea;
    end else begin
      sr = (1 << fw) | fa; er = ea; ss = (1 << fw) | fb; es = eb;
    end
    d   = er - es;
    sm  = (d >= fw + 1) ? 0 : (ss >> d);
    s   = sr + sm;
    ro  = 0;
    tag = (d >= fw + 1) ? "R4" : "R3";
    if (s >= (2 << fw)) begin
      if (er == emax) begin
        rf = mask; re = emax; ro = 1; tag = "R6";
      end else begin
        rf = (s >> 1) & mask; re = er + 1; tag = "R5";
      end
    end else begin
      rf = s & mask; re = er;
    end
  endfunction

  task automatic run_op(input int fa, input int ea, input int fb, input int eb);
    int rf, re, ro;
    string tag;
    model(FW, EW, fa, ea, fb, eb, rf, re, ro, tag);
    start = 1'b1;
    a_frac = FW'(fa); a_exp = EW'(ea); b_frac = FW'(fb); b_exp = EW'(eb);
    @(negedge clk);
    check("R2", "ready while busy", int'(ready), 0);
    start = 1'b0;
    @(negedge clk);
    check("R2", "done pulse", int'(done), 1);
    check(tag, "sum_frac", int'(sum_frac), rf);
    check(tag, "sum_exp", int'(sum_exp), re);
    check((ro != 0) ? "R6" : tag, "overflow", int'(overflow), ro);
  endtask

  task automatic run_wide(input int fa, input int ea, input int fb, input int eb);
    int rf, re, ro;
    string tag;
    model(FW, EWW, fa, ea, fb, eb, rf, re, ro, tag);
    w_start = 1'b1;
    w_a_frac = FW'(fa); w_a_exp = EWW'(ea); w_b_frac = FW'(fb); w_b_exp = EWW'(eb);
    @(negedge clk);
    w_start = 1'b0;
    @(negedge clk);
    check("R2", "wide done pulse", int'(w_done), 1);
    check(tag, "wide sum_frac", int'(w_sum_frac), rf);
    check(tag, "wide sum_exp", int'(w_sum_exp), re);
    check((ro != 0) ? "R6" : tag, "wide overflow", int'(w_overflow), ro);
  endtask

  initial begin
    int hf, he;
    repeat (3) @(negedge clk);
    // R1: values during reset
    check("R1", "ready in reset", int'(ready), 1);
    check("R1", "done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    // R1: values after reset release
    check("R1", "ready after reset", int'(ready), 1);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "overflow after reset", int'(overflow), 0);
    check("R1", "sum_frac after reset", int'(sum_frac), 0);
    check("R1", "sum_exp after reset", int'(sum_exp), 0);

    // R5: worked example (11000000,011)+(10101100,100) -> (01000110,101)
    run_op(8'b11000000, 3'b011, 8'b10101100, 3'b100);
    check("R5", "example frac", int'(sum_frac), 8'b01000110);
    check("R5", "example exp", int'(sum_exp), 3'b101);

    // R3 R5 R6: all exponent pairs over a fraction grid, back to back
    for (int ea = 0; ea < 8; ea++)
      for (int eb = 0; eb < 8; eb++)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++)
            run_op(i * 17, ea, j * 17, eb);

    @(negedge clk);
    check("R2", "done lasts one cycle", int'(done), 0);

    // R2 R7: start during busy cycle is ignored
    start = 1'b1;
    a_frac = 8'h10; a_exp = 3'd2; b_frac = 8'h20; b_exp = 3'd2;
    @(negedge clk);
    a_frac = 8'hFF; a_exp = 3'd7; b_frac = 8'hFF; b_exp = 3'd7;
    @(negedge clk);
    start = 1'b0;
    check("R2", "first result frac after busy start", int'(sum_frac), 8'h18);
    check("R2", "first result exp after busy start", int'(sum_exp), 3);
    check("R2", "first result overflow", int'(overflow), 0);
    @(negedge clk);
    check("R2", "no extra done", int'(done), 0);
    check("R2", "idle after ignored start", int'(ready), 1);
    hf = int'(sum_frac); he = int'(sum_exp);
    a_frac = 8'h00; b_frac = 8'h55; a_exp = 3'd1; b_exp = 3'd6;
    repeat (4) @(negedge clk);
    // R7: outputs held while idle with moving inputs
    check("R7", "held frac", int'(sum_frac), hf);
    check("R7", "held exp", int'(sum_exp), he);
    check("R7", "held done low", int'(done), 0);

    // R4 R6: wider exponent, differences up to 15
    for (int ea = 0; ea < 16; ea++)
      for (int eb = 0; eb < 16; eb++)
        for (int i = 0; i < 4; i++)
          run_wide(i * 85, ea, 255 - i * 85, eb);
    run_wide(8'h3C, 15, 8'hFF, 6);
    check("R4", "far operand dropped", int'(w_sum_frac), 8'h3C);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule